// File: doc/BRIEF.md
# Timer Parameter Staging Unit

This block holds the trigger input (IN) and preset time (PT) for an array of addressed timer channels inside a controller core with a one-bit boolean accumulator and a word accumulator. The boolean accumulator is the only source of IN, and the word accumulator is the only source of PT. Every channel keeps two register levels for each parameter. A store operation writes the staging level. A call operation copies both staged values into the active level, and only the active level is seen by the timer logic.

Programs can drive a channel in two ways. In the first, store operations prepare the staging registers and a separate call commits them. In the second, a short operator writes one parameter and performs the call in the same operation. The unit decodes a 3-bit operation code against a channel address. It presents the active IN and PT of every channel in parallel, and it raises a one-cycle call strobe toward the addressed channel whenever a call takes place. The counting logic of the timers is outside this block.

Top module: `timer_param_stage`

## Requirements
- R1: A synchronous active-high reset clears every staged and active IN to 0, every staged and active PT to 0, and all call strobes. The outputs read zero from the first clock edge with reset high.
- R2: Operation code 1 (store IN) writes the boolean accumulator into the staging IN of the addressed channel. Operation code 2 (store PT) writes the word accumulator into the staging PT of the addressed channel. Neither changes any active output or raises a call strobe.
- R3: Operation code 3 (call) copies the staged IN and staged PT of the addressed channel into its active registers. The new values appear on `in_act` and `pt_act` one clock after the operation.
- R4: Operation code 4 (short IN) loads the boolean accumulator directly into the active IN of the addressed channel. In the same clock it commits that channel's staged PT, as a call does.
- R5: Operation code 5 (short PT) loads the word accumulator directly into the active PT of the addressed channel. In the same clock it commits that channel's staged IN, as a call does.
- R6: A short operator also writes the staging register of the parameter it targets, so that a later call keeps the value the short operator set.
- R7: Only the channel whose index equals `addr` is affected. An address at or above the channel count, operation code 0 (no operation), and operation codes 6 and 7 change no register and raise no strobe.
- R8: After an operation with code 3, 4 or 5, bit `addr` of `call_pulse` is high for exactly one cycle, the cycle after the operation. At most one strobe bit is high at any time.
- R9: A call commits the previously stored value of any parameter that has not been written again since. Repeated calls with no store in between leave the active values unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | AW | Channel index |
| op_code | input | 3 | Operation: 0 none, 1 store IN, 2 store PT, 3 call, 4 short IN, 5 short PT |
| acc_b | input | 1 | Boolean accumulator value |
| acc_w | input | PT_W | Word accumulator value |
| in_act | output | NUM_CH | Active IN of each channel, bit i for channel i |
| pt_act | output | NUM_CH*PT_W | Active PT of each channel, channel i at bits i*PT_W upward |
| call_pulse | output | NUM_CH | One-cycle call strobe per channel |

## Verification
The bench builds the unit with six channels and a 16-bit PT. Because six is not a power of two, the 3-bit address can take the values 6 and 7, which select no channel, so the out-of-range rule of R7 can be exercised. The narrower PT keeps the expected vectors short while still separating channel fields. The sequences mix store-then-call programming with short operators on the same channels. This shows that staged values survive a short operator on the other parameter and that a call after a short operator does not bring back a stale value.

// File: rtl/tstg_pkg.sv
package tstg_pkg;

  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_ST_IN = 3'd1,
    OP_ST_PT = 3'd2,
    OP_CALL  = 3'd3,
    OP_SH_IN = 3'd4,
    OP_SH_PT = 3'd5
  } tstg_op_e;

  // Decoded per-operation controls shared by every channel
  typedef struct packed {
    logic wr_stg_in;  // write staging IN
    logic wr_stg_pt;  // write staging PT
    logic commit;     // load active level (call semantics)
    logic byp_in;     // active IN taken from accumulator instead of staging
    logic byp_pt;     // active PT taken from accumulator instead of staging
  } tstg_ctl_t;

endpackage

// File: rtl/tstg_decode.sv
module tstg_decode
  import tstg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int AW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [AW-1:0]     addr,
  input  logic [2:0]        op_code,
  output logic [NUM_CH-1:0] sel,
  output tstg_ctl_t         ctl
);

  localparam logic [AW:0] CH_LIM = (AW+1)'(NUM_CH);

  logic addr_ok;
  logic op_live;

  assign addr_ok = ({1'b0, addr} < CH_LIM);

  always_comb begin
    ctl     = '0;
    op_live = 1'b1;
    unique case (op_code)
      OP_ST_IN: ctl.wr_stg_in = 1'b1;
      OP_ST_PT: ctl.wr_stg_pt = 1'b1;
      OP_CALL:  ctl.commit    = 1'b1;
      OP_SH_IN: begin
        ctl.wr_stg_in = 1'b1;
        ctl.commit    = 1'b1;
        ctl.byp_in    = 1'b1;
      end
      OP_SH_PT: begin
        ctl.wr_stg_pt = 1'b1;
        ctl.commit    = 1'b1;
        ctl.byp_pt    = 1'b1;
      end
      default: op_live = 1'b0;
    endcase
  end

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_sel
    assign sel[gi] = op_live && addr_ok && (addr == AW'(gi));
  end

endmodule

// File: rtl/tstg_chan.sv
module tstg_chan
  import tstg_pkg::*;
#(
  parameter int PT_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  tstg_ctl_t       ctl,
  input  logic            acc_b,
  input  logic [PT_W-1:0] acc_w,
  output logic            act_in,
  output logic [PT_W-1:0] act_pt,
  output logic            call_q
);

  logic            stg_in;
  logic [PT_W-1:0] stg_pt;

  // Staging level
  always_ff @(posedge clk) begin
    if (rst) begin
      stg_in <= 1'b0;
      stg_pt <= '0;
    end else if (en) begin
      if (ctl.wr_stg_in) stg_in <= acc_b;
      if (ctl.wr_stg_pt) stg_pt <= acc_w;
    end
  end

  // Active level: staged value, or accumulator for the short-operator path
  always_ff @(posedge clk) begin
    if (rst) begin
      act_in <= 1'b0;
      act_pt <= '0;
    end else if (en && ctl.commit) begin
      act_in <= ctl.byp_in ? acc_b : stg_in;
      act_pt <= ctl.byp_pt ? acc_w : stg_pt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) call_q <= 1'b0;
    else     call_q <= en && ctl.commit;
  end

endmodule

// File: rtl/timer_param_stage.sv
module timer_param_stage
  import tstg_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PT_W   = 32,
  parameter int AW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [AW-1:0]          addr,
  input  logic [2:0]             op_code,
  input  logic                   acc_b,
  input  logic [PT_W-1:0]        acc_w,
  output logic [NUM_CH-1:0]      in_act,
  output logic [NUM_CH*PT_W-1:0] pt_act,
  output logic [NUM_CH-1:0]      call_pulse
);

  logic [NUM_CH-1:0] sel;
  tstg_ctl_t         ctl;

  tstg_decode #(.NUM_CH(NUM_CH), .AW(AW)) u_dec (
    .addr    (addr),
    .op_code (op_code),
    .sel     (sel),
    .ctl     (ctl)
  );

  for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
    tstg_chan #(.PT_W(PT_W)) u_ch (
      .clk    (clk),
      .rst    (rst),
      .en     (sel[gc]),
      .ctl    (ctl),
      .acc_b  (acc_b),
      .acc_w  (acc_w),
      .act_in (in_act[gc]),
      .act_pt (pt_act[gc*PT_W +: PT_W]),
      .call_q (call_pulse[gc])
    );
  end

endmodule

// File: rtl/tstg_checker.sv
module tstg_checker #(
  parameter int NUM_CH = 8,
  parameter int PT_W   = 32,
  parameter int AW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                   clk,
  input logic                   rst,
  input logic [AW-1:0]          addr,
  input logic [2:0]             op_code,
  input logic                   acc_b,
  input logic [PT_W-1:0]        acc_w,
  input logic [NUM_CH-1:0]      in_act,
  input logic [NUM_CH*PT_W-1:0] pt_act,
  input logic [NUM_CH-1:0]      call_pulse
);

  localparam logic [AW:0] CH_LIM = (AW+1)'(NUM_CH);

  logic [PT_W-1:0] pt_ch [NUM_CH];
  logic            a_ok;

  for (genvar gk = 0; gk < NUM_CH; gk++) begin : g_unp
    assign pt_ch[gk] = pt_act[gk*PT_W +: PT_W];
  end
  assign a_ok = ({1'b0, addr} < CH_LIM);

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $past(rst) |-> (in_act == '0 && pt_act == '0 && call_pulse == '0)); // R1

  AST_STORE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd1 || op_code == 3'd2)
    |=> ($stable(in_act) && $stable(pt_act) && call_pulse == '0)); // R2

  AST_SHORT_IN_LOADS: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd4 && a_ok) |=> (in_act[$past(addr)] == $past(acc_b))); // R4

  AST_SHORT_PT_LOADS: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd5 && a_ok) |=> (pt_ch[$past(addr)] == $past(acc_w))); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (op_code == 3'd0 || op_code > 3'd5 || !a_ok)
    |=> ($stable(in_act) && $stable(pt_act) && call_pulse == '0)); // R7

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(call_pulse)); // R8

  AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (call_pulse != '0) |-> ($past(op_code) inside {3'd3, 3'd4, 3'd5})); // R8

  AST_CALL_STROBES: assert property (@(posedge clk) disable iff (rst)
    ((op_code inside {3'd3, 3'd4, 3'd5}) && a_ok)
    |=> ($countones(call_pulse) == 1 && call_pulse[$past(addr)])); // R8

endmodule

bind timer_param_stage tstg_checker #(
  .NUM_CH(NUM_CH), .PT_W(PT_W), .AW(AW)
) u_tstg_chk (.*);

// File: tb/tb_timer_param_stage.sv
`timescale 1ns/1ps
module tb_timer_param_stage;

  localparam int NCH = 6;
  localparam int PW  = 16;
  localparam int AWB = 3;

  // Operation codes as given in the requirements
  localparam logic [2:0] K_NOP = 3'd0, K_SIN = 3'd1, K_SPT = 3'd2,
                         K_CAL = 3'd3, K_HIN = 3'd4, K_HPT = 3'd5;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic [AWB-1:0]     addr = '0;
  logic [2:0]         op_code = K_NOP;
  logic               acc_b = 1'b0;
  logic [PW-1:0]      acc_w = '0;
  logic [NCH-1:0]     in_act;
  logic [NCH*PW-1:0]  pt_act;
  logic [NCH-1:0]     call_pulse;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  timer_param_stage #(.NUM_CH(NCH), .PT_W(PW)) dut (
    .clk(clk), .rst(rst), .addr(addr), .op_code(op_code),
    .acc_b(acc_b), .acc_w(acc_w),
    .in_act(in_act), .pt_act(pt_act), .call_pulse(call_pulse)
  );

  // Reference model state
  logic          m_stg_in [NCH];
  logic [PW-1:0] m_stg_pt [NCH];
  logic          m_act_in [NCH];
  logic [PW-1:0] m_act_pt [NCH];

  // Scoreboard queues
  logic [NCH-1:0]    q_in  [$];
  logic [NCH*PW-1:0] q_pt  [$];
  logic [NCH-1:0]    q_pl  [$];
  int                q_due [$];
  string             q_tag [$];

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_stg_in[i] = 1'b0; m_stg_pt[i] = '0;
      m_act_in[i] = 1'b0; m_act_pt[i] = '0;
    end
  endtask

  task automatic do_op(input logic [2:0] op, input int a, input logic b,
                       input logic [PW-1:0] w, input string tag);
    logic [NCH-1:0]    e_in;
    logic [NCH*PW-1:0] e_pt;
    logic [NCH-1:0]    e_pl;
    @(negedge clk);
    op_code = op; addr = AWB'(a); acc_b = b; acc_w = w;
    e_pl = '0;
    if (a < NCH) begin
      case (op)
        K_SIN: m_stg_in[a] = b;
        K_SPT: m_stg_pt[a] = w;
        K_CAL: begin
          m_act_in[a] = m_stg_in[a]; m_act_pt[a] = m_stg_pt[a]; e_pl[a] = 1'b1;
        end
        K_HIN: begin
          m_stg_in[a] = b; m_act_in[a] = b; m_act_pt[a] = m_stg_pt[a]; e_pl[a] = 1'b1;
        end
        K_HPT: begin
          m_stg_pt[a] = w; m_act_pt[a] = w; m_act_in[a] = m_stg_in[a]; e_pl[a] = 1'b1;
        end
        default: ;
      endcase
    end
    for (int i = 0; i < NCH; i++) begin
      e_in[i] = m_act_in[i];
      e_pt[i*PW +: PW] = m_act_pt[i];
    end
    q_in.push_back(e_in); q_pt.push_back(e_pt); q_pl.push_back(e_pl);
    q_due.push_back(cyc + 1); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      op_code = K_NOP;
    end
  endtask

  // Monitor: compare outputs once the expected item is due
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q_due.size() > 0 && q_due[0] <= cyc) begin
        logic [NCH-1:0]    x_in;
        logic [NCH*PW-1:0] x_pt;
        logic [NCH-1:0]    x_pl;
        string             t;
        x_in = q_in.pop_front(); x_pt = q_pt.pop_front();
        x_pl = q_pl.pop_front(); t = q_tag.pop_front();
        void'(q_due.pop_front());
        checks++;
        if (in_act !== x_in || pt_act !== x_pt || call_pulse !== x_pl) begin
          fails++;
          $display("FAIL %s: in_act=%b exp %b pt_act=%h exp %h call_pulse=%b exp %b",
                   t, in_act, x_in, pt_act, x_pt, call_pulse, x_pl);
        end
      end
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (in_act !== '0 || pt_act !== '0 || call_pulse !== '0) begin
      fails++;
      $display("FAIL R1 reset: in_act=%b pt_act=%h call_pulse=%b exp all 0",
               in_act, pt_act, call_pulse);
    end
    rst = 1'b0;

    // Two-level programming
    do_op(K_SIN, 2, 1'b1, 16'h0000, "R2 store IN ch2 leaves active");
    do_op(K_SPT, 2, 1'b0, 16'h1234, "R2 store PT ch2 leaves active");
    do_op(K_CAL, 2, 1'b0, 16'hFFFF, "R3 call ch2 commits staged");
    do_op(K_NOP, 2, 1'b1, 16'hFFFF, "R8 strobe lasts one cycle");
    do_op(K_CAL, 2, 1'b0, 16'h0000, "R9 repeated call keeps values");
    do_op(K_SPT, 2, 1'b0, 16'h0055, "R2 restage PT ch2");
    do_op(K_CAL, 2, 1'b0, 16'h0000, "R9 call keeps earlier staged IN");

    // Short IN
    do_op(K_HIN, 0, 1'b1, 16'h9999, "R4 short IN ch0 direct load");
    do_op(K_SPT, 0, 1'b1, 16'h0777, "R2 stage PT ch0");
    do_op(K_HIN, 0, 1'b0, 16'h9999, "R4 short IN commits staged PT");

    // Short PT
    do_op(K_HPT, 5, 1'b1, 16'hBEEF, "R5 short PT ch5 direct load");
    do_op(K_SIN, 5, 1'b1, 16'h0000, "R2 stage IN ch5");
    do_op(K_HPT, 5, 1'b0, 16'h0101, "R5 short PT commits staged IN");

    // Short operators also refresh staging
    do_op(K_HIN, 3, 1'b1, 16'h0000, "R6 short IN ch3");
    do_op(K_CAL, 3, 1'b0, 16'h0000, "R6 call after short IN keeps IN");
    do_op(K_HPT, 4, 1'b0, 16'hAAAA, "R6 short PT ch4");
    do_op(K_CAL, 4, 1'b1, 16'h0000, "R6 call after short PT keeps PT");

    // Ignored operations and addresses
    do_op(K_HIN, 6, 1'b1, 16'h1111, "R7 address 6 ignored");
    do_op(K_HPT, 7, 1'b1, 16'h2222, "R7 address 7 ignored");
    do_op(K_CAL, 7, 1'b1, 16'h3333, "R7 call to address 7 ignored");
    do_op(3'd6, 1, 1'b1, 16'h4444, "R7 code 6 ignored");
    do_op(3'd7, 1, 1'b1, 16'h5555, "R7 code 7 ignored");
    do_op(K_CAL, 1, 1'b1, 16'h6666, "R7 ch1 staging untouched by codes 6 and 7");
    do_op(K_HIN, 1, 1'b1, 16'h0000, "R8 strobe on ch1 only, others held");

    idle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule